// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This block keeps a signed 64-bit accumulator as two 32-bit halves, a high word and a low word. Each strobed operation forms a signed product and adds it to the concatenation {high, low}. The 64-bit sum is then split back into the two halves. There are two operations. The long operation multiplies both full 32-bit operands as signed values. The word operation uses only the signed low 16 bits of each operand.

A saturation-mode input picks an optional clamp, applied after the addition, and its rule depends on the operation. For the long operation the clamp masks the high word according to the sign of the sum. For the word operation the clamp limits the sum to the signed 32-bit range and sets the high word to one as an overflow marker.

The accumulator can also be cleared, and either half can be loaded directly. Both halves are visible at all times as registered outputs, and the result of an operation appears one clock after its strobe.

Top module: `mac_acc`

## Requirements
- R1: While rst_n is low at a rising clock edge, both halves become zero after that edge.
- R2: With op_long_i=1 and sat_i=0, a strobe adds the signed 32x32 product of opa_i and opb_i to {acc_hi_o, acc_lo_o}, wrapping modulo 2^64, and the result is visible after the next rising edge.
- R3: With op_long_i=0 and sat_i=0, a strobe adds the signed product of opa_i[15:0] and opb_i[15:0]. Bits 31:16 of the operands have no effect, and the sum wraps modulo 2^64.
- R4: With op_long_i=1 and sat_i=1, a negative 64-bit sum has acc_hi_o[31:16] forced to 0xFFFF, and all other bits keep the sum.
- R5: With op_long_i=1 and sat_i=1, a non-negative sum has acc_hi_o[31:15] forced to zero, and all other bits keep the sum.
- R6: With op_long_i=0 and sat_i=1, a sum below -2^31 gives acc_hi_o=1 and acc_lo_o=0x80000000.
- R7: With op_long_i=0 and sat_i=1, a sum above 2^31-1 gives acc_hi_o=1 and acc_lo_o=0x7FFFFFFF.
- R8: With op_long_i=0 and sat_i=1, a sum inside [-2^31, 2^31-1] is stored unchanged.
- R9: clr_i zeroes both halves at the next edge. It wins over a strobe and over direct writes in the same cycle.
- R10: wr_hi_i loads wr_data_i into the high word and wr_lo_i loads it into the low word. When either write is active, a strobe in that cycle is ignored, and a half that is not written keeps its value.
- R11: With no strobe, no clear and no write, both halves hold their values whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Strobe that performs one multiply-accumulate |
| op_long_i | input | 1 | 1 = long operation (32x32), 0 = word operation (16x16) |
| sat_i | input | 1 | Saturation mode for the strobed operation |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| clr_i | input | 1 | Synchronous accumulator clear |
| wr_hi_i | input | 1 | Load wr_data_i into the high word |
| wr_lo_i | input | 1 | Load wr_data_i into the low word |
| wr_data_i | input | 32 | Data for direct writes |
| acc_hi_o | output | 32 | High word of the accumulator |
| acc_lo_o | output | 32 | Low word of the accumulator |

## Verification
Directed cases place the accumulator exactly at the signed 32-bit limits, so that the word clamp's upper marker, lower marker and in-range pass-through are each told apart by a single unit of product. Other directed cases put a sign-bit-only high word under the long clamp, which separates the negative mask from the non-negative mask. Operands with non-zero upper halves show whether the word operation ignores bits 31:16. Runs of seeded random operations, saturation modes, preloads and clears then check the wrap-around accumulate against a reference model, and a strobe is also placed in the same cycle as a clear or a write to test the priority order.

// File: rtl/mac_pkg.sv
// Shared definitions for the multiply-accumulate unit.
// Assumes: halves are two's complement words; the accumulator is {hi, lo}.
package mac_pkg;
    localparam int MAC_HALF_W  = 32;
    localparam int MAC_SHORT_W = 16;

    typedef enum logic {
        OP_WORD = 1'b0,
        OP_LONG = 1'b1
    } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
// Signed product former.
// Long op: full HALF_W x HALF_W signed product.
// Word op: signed product of the low SHORT_W bits of each operand,
// sign-extended to the accumulator width.
// Assumes: SHORT_W <= HALF_W; purely combinational.
module mac_mult
    import mac_pkg::*;
#(
    parameter int HALF_W  = MAC_HALF_W,
    parameter int SHORT_W = MAC_SHORT_W,
    localparam int ACC_W  = 2 * HALF_W
) (
    input  mac_op_e           op_i,
    input  logic [HALF_W-1:0] a_i,
    input  logic [HALF_W-1:0] b_i,
    output logic [ACC_W-1:0]  prod_o
);
    logic signed [HALF_W-1:0]    a_full, b_full;
    logic signed [SHORT_W-1:0]   a_short, b_short;
    logic signed [ACC_W-1:0]     p_long;
    logic signed [2*SHORT_W-1:0] p_short;

    // Operand views and the two candidate products.
    always_comb begin
        a_full  = a_i;
        b_full  = b_i;
        a_short = a_i[SHORT_W-1:0];
        b_short = b_i[SHORT_W-1:0];
        p_long  = a_full * b_full;
        p_short = a_short * b_short;
    end

    // Select the product by operation, sign-extending the short one.
    always_comb begin
        if (op_i == OP_LONG)
            prod_o = p_long;
        else
            prod_o = {{(ACC_W-2*SHORT_W){p_short[2*SHORT_W-1]}}, p_short};
    end
endmodule

// File: rtl/mac_sat.sv
// Post-addition clamp.
// Long op, saturation on: a negative sum forces the top HALF_W/2 bits of
// the high word to ones; a non-negative sum clears the top HALF_W/2+1 bits.
// Word op, saturation on: a sum outside the signed HALF_W range becomes
// high = 1 with the low word at the nearer signed limit.
// Assumes: the sum is already wrapped modulo 2^ACC_W; combinational.
module mac_sat
    import mac_pkg::*;
#(
    parameter int HALF_W = MAC_HALF_W,
    localparam int ACC_W = 2 * HALF_W,
    localparam int TOP_N = HALF_W / 2
) (
    input  mac_op_e          op_i,
    input  logic             sat_i,
    input  logic [ACC_W-1:0] sum_i,
    output logic [ACC_W-1:0] res_o
);
    logic                    neg;
    logic                    out_of_range;
    logic [ACC_W-1:0]        long_clamped;
    logic [ACC_W-1:0]        word_clamped;
    logic [HALF_W-1:0]       lim_lo;

    // Range tests: the upper bits must all equal the low word's sign bit.
    always_comb begin
        neg          = sum_i[ACC_W-1];
        out_of_range = !((&sum_i[ACC_W-1:HALF_W-1]) || !(|sum_i[ACC_W-1:HALF_W-1]));
        lim_lo       = neg ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}};
    end

    // Long-operation mask on the high word.
    always_comb begin
        if (neg)
            long_clamped = {{TOP_N{1'b1}}, sum_i[ACC_W-TOP_N-1:0]};
        else
            long_clamped = {{(TOP_N+1){1'b0}}, sum_i[ACC_W-TOP_N-2:0]};
    end

    // Word-operation limit with the overflow marker in the high word.
    always_comb begin
        if (out_of_range)
            word_clamped = {HALF_W'(1), lim_lo};
        else
            word_clamped = sum_i;
    end

    // Final choice by mode and operation.
    always_comb begin
        if (!sat_i)
            res_o = sum_i;
        else if (op_i == OP_LONG)
            res_o = long_clamped;
        else
            res_o = word_clamped;
    end
endmodule

// File: rtl/mac_acc.sv
// Top of the multiply-accumulate unit: accumulator registers and priority.
// Priority per cycle: reset, clear, direct half writes, strobed accumulate.
// Assumes: all controls are synchronous to clk; results appear one edge
// after the strobe.
module mac_acc
    import mac_pkg::*;
#(
    parameter int HALF_W  = MAC_HALF_W,
    parameter int SHORT_W = MAC_SHORT_W,
    localparam int ACC_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_long_i,
    input  logic              sat_i,
    input  logic [HALF_W-1:0] opa_i,
    input  logic [HALF_W-1:0] opb_i,
    input  logic              clr_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [HALF_W-1:0] wr_data_i,
    output logic [HALF_W-1:0] acc_hi_o,
    output logic [HALF_W-1:0] acc_lo_o
);
    mac_op_e           op;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  sum;
    logic [ACC_W-1:0]  next_acc;
    logic [HALF_W-1:0] hi_q, lo_q;

    // Decode the operation select.
    always_comb op = op_long_i ? OP_LONG : OP_WORD;

    mac_mult #(.HALF_W(HALF_W), .SHORT_W(SHORT_W)) u_mult (
        .op_i   (op),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (prod)
    );

    // Wrap-around 64-bit accumulate.
    always_comb sum = {hi_q, lo_q} + prod;

    mac_sat #(.HALF_W(HALF_W)) u_sat (
        .op_i  (op),
        .sat_i (sat_i),
        .sum_i (sum),
        .res_o (next_acc)
    );

    // Accumulator update with clear > write > accumulate priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_hi_i || wr_lo_i) begin
            if (wr_hi_i) hi_q <= wr_data_i;
            if (wr_lo_i) lo_q <= wr_data_i;
        end else if (start_i) begin
            hi_q <= next_acc[ACC_W-1:HALF_W];
            lo_q <= next_acc[HALF_W-1:0];
        end
    end

    assign acc_hi_o = hi_q;
    assign acc_lo_o = lo_q;

    // R1: reset empties the accumulator.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_hi_o == '0 && acc_lo_o == '0));

    // R9: clear wins over everything else.
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_hi_o == '0 && acc_lo_o == '0));

    // R10: a high-word write lands exactly.
    assert_write_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !clr_i) |=> acc_hi_o == $past(wr_data_i));

    // R10: a low-word write lands exactly.
    assert_write_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !clr_i) |=> acc_lo_o == $past(wr_data_i));

    // R11: idle cycles keep the accumulator.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !clr_i && !wr_hi_i && !wr_lo_i) |=> ($stable(acc_hi_o) && $stable(acc_lo_o)));

    // R4 and R5: the long clamp leaves a high word with a uniform top field.
    assert_long_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_long_i && sat_i && !clr_i && !wr_hi_i && !wr_lo_i)
        |=> (acc_hi_o[HALF_W-1:HALF_W/2-1] == '0 || acc_hi_o[HALF_W-1:HALF_W/2] == '1));

    // R6, R7 and R8: the word clamp yields an in-range value or a marker.
    assert_word_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !op_long_i && sat_i && !clr_i && !wr_hi_i && !wr_lo_i)
        |=> ((acc_hi_o == '0 && !acc_lo_o[HALF_W-1]) ||
             (acc_hi_o == '1 && acc_lo_o[HALF_W-1]) ||
             (acc_hi_o == HALF_W'(1) &&
              (acc_lo_o == {1'b1, {(HALF_W-1){1'b0}}} || acc_lo_o == {1'b0, {(HALF_W-1){1'b1}}}))));
endmodule

// File: tb/mac_acc_tb.sv
module mac_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, op_long_i = 1'b0, sat_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0, wr_data_i = '0;
    logic        clr_i = 1'b0, wr_hi_i = 1'b0, wr_lo_i = 1'b0;
    logic [31:0] acc_hi_o, acc_lo_o;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] model = '0;

    always #2 clk = ~clk;

    mac_acc u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_long_i(op_long_i),
        .sat_i(sat_i), .opa_i(opa_i), .opb_i(opb_i), .clr_i(clr_i),
        .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wr_data_i(wr_data_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
    );

    // Reference accumulate from the requirements.
    function automatic logic [63:0] ref_mac(input logic [63:0] acc, input logic [31:0] a,
                                            input logic [31:0] b, input logic lng, input logic sat);
        logic signed [63:0] p, r;
        if (lng) p = 64'(signed'(a)) * 64'(signed'(b));
        else     p = 64'(signed'(a[15:0])) * 64'(signed'(b[15:0]));
        r = signed'(acc + p);
        if (sat) begin
            if (lng) begin
                if (r < 0) r[63:48] = 16'hFFFF;
                else       r[63:47] = 17'h0;
            end else if (r < -64'sd2147483648) begin
                r = {32'd1, 32'h80000000};
            end else if (r > 64'sd2147483647) begin
                r = {32'd1, 32'h7FFFFFFF};
            end
        end
        return r;
    endfunction

    task automatic check(input string tag);
        checks++;
        if ({acc_hi_o, acc_lo_o} !== model) begin
            errors++;
            $display("FAIL %s actual %h_%h expected %h_%h", tag, acc_hi_o, acc_lo_o,
                     model[63:32], model[31:0]);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, sample after the rising edge.
    task automatic step(input logic st, input logic lng, input logic sat,
                        input logic [31:0] a, input logic [31:0] b, input logic clr,
                        input logic whi, input logic wlo, input logic [31:0] wd, input string tag);
        @(negedge clk);
        start_i = st; op_long_i = lng; sat_i = sat; opa_i = a; opb_i = b;
        clr_i = clr; wr_hi_i = whi; wr_lo_i = wlo; wr_data_i = wd;
        if (clr) model = '0;
        else if (whi || wlo) begin
            if (whi) model[63:32] = wd;
            if (wlo) model[31:0] = wd;
        end else if (st) model = ref_mac(model, a, b, lng, sat);
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] lo);
        step(0, 0, 0, 0, 0, 0, 1, 0, hi, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 1, lo, "R10");
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;

        load(32'h12345678, 32'h9ABCDEF0);
        step(0, 1, 0, 32'h55, 32'h66, 0, 0, 0, 0, "R11");
        step(1, 1, 0, 32'hFFFFFFFD, 32'd5, 1, 1, 0, 32'h1, "R9");
        step(1, 1, 0, 32'hFFFFFFFD, 32'd5, 0, 0, 0, 0, "R2");
        load(32'hFFFFFFFF, 32'hFFFFFFFF);
        step(1, 1, 0, 32'd1, 32'd1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 32'hFFFF0003, 32'h7777FFFE, 0, 0, 0, 0, "R3");
        load(32'h0, 32'h7FFFFFFF);
        step(1, 0, 0, 32'h00010001, 32'hABCD0001, 0, 0, 0, 0, "R3");
        load(32'h80000000, 32'h0);
        step(1, 1, 1, 32'h0, 32'h0, 0, 0, 0, 0, "R4");
        load(32'h7FFFFFFF, 32'h5);
        step(1, 1, 1, 32'h0, 32'h0, 0, 0, 0, 0, "R5");
        load(32'hFFFFFFFF, 32'h80000000);
        step(1, 0, 1, 32'hFFFF, 32'd1, 0, 0, 0, 0, "R6");
        load(32'h0, 32'h7FFFFFFF);
        step(1, 0, 1, 32'd1, 32'd1, 0, 0, 0, 0, "R7");
        load(32'h0, 32'h7FFFFFFE);
        step(1, 0, 1, 32'd1, 32'd1, 0, 0, 0, 0, "R8");
        step(1, 1, 0, 32'd7, 32'd9, 0, 0, 1, 32'hCAFEF00D, "R10");
        step(0, 1, 1, 32'hFFFFFFFF, 32'h7FFFFFFF, 0, 0, 0, 0, "R11");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r, a, b;
            logic lng, sat;
            string tag;
            r = $urandom; a = $urandom; b = $urandom;
            lng = r[0]; sat = r[1];
            if (r[3:2] == 2'b00) begin
                a = {$urandom_range(0, 1) ? 16'hFFFF : 16'h0, a[15:0]};
                b = b & 32'h0000FFFF;
            end
            tag = lng ? (sat ? "R4" : "R2") : (sat ? "R6" : "R3");
            if (r[9:4] == 6'd0)
                step(1, lng, sat, a, b, 1, 0, 0, 0, "R9");
            else if (r[9:4] < 6'd4)
                step(r[10], lng, sat, a, b, 0, r[11], !r[11], $urandom, "R10");
            else if (r[9:4] < 6'd7)
                load(r[12] ? 32'hFFFFFFFF : 32'h0, $urandom);
            else if (r[9:4] < 6'd10)
                step(0, lng, sat, a, b, 0, 0, 0, 0, "R11");
            else
                step(1, lng, sat, a, b, 0, 0, 0, 0, tag);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule